// File: doc/BRIEF.md
# Shared Address/Data Bus Word Target

This block is the target side of a clocked bus whose 32 lines carry first an address and then data. A transaction opens with one address cycle. In that cycle the initiator pulls `frame_n` low, places the byte address on the shared lines and places a command code on the four command/byte-select lines. The next cycle is a turnaround, in which nobody drives the shared lines. After that the four command/byte-select lines carry an active-low byte mask for the data word.

The target compares the address with a fixed, size-aligned window. If the address falls inside the window and the command is a word read or a word write, the target claims the cycle. Behind the bus sits a local word memory made of four byte lanes. A `mem_ready` input says whether that memory can be accessed. While it is low, the target adds wait states.

Each transaction moves exactly one word. All bus control signals are active low. The shared lines are split into an input bus, an output bus and an output enable, so the block can be placed on a chip-level pad or fabric tristate.

Top module: `mxbus_target`

## Requirements
- R1: While `rst` is high, `devsel_n` and `trdy_n` read 1 and `ad_oe` reads 0 from the first clock edge onward.
- R2: An address cycle is one in which `frame_n` is sampled low while the target is idle. If that cycle's address lies in [`BASE_ADDR`, `BASE_ADDR` + 4·`WORDS`) and its command is 4'b0110 (word read) or 4'b0111 (word write), `devsel_n` goes low in the next cycle. It stays low until the data phase completes.
- R3: `ad_oe` is 0 during the address cycle and during the turnaround cycle after it. It is also 0 throughout any write.
- R4: `trdy_n` goes low one cycle after the first cycle, counting from the turnaround cycle, in which `mem_ready` is high. Until then each cycle with `mem_ready` low adds one wait state.
- R5: In a read, from the first cycle with `trdy_n` low, `ad_oe` is 1 and `ad_o` holds the stored word at word index address[`IDX_W`+1:2].
- R6: The data phase completes at a clock edge where `trdy_n` and `irdy_n` are both low. In the following cycle `devsel_n` and `trdy_n` are 1 and `ad_oe` is 0.
- R7: While `trdy_n` is low and `irdy_n` is high, `trdy_n` stays low and `ad_o` does not change.
- R8: A write changes byte k (bits 8k+7:8k) of the addressed word to `ad_i` only if bit k of `cbe_n` is low at the completing edge. The other bytes keep their values.
- R9: An address outside the window, or any other command code, produces no `devsel_n`, no `trdy_n` and no drive. The target then ignores the bus until `frame_n` is sampled high, and the memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Transaction start from the initiator, active low |
| irdy_n | input | 1 | Initiator ready for the data phase, active low |
| cbe_n | input | 4 | Command in the address cycle; active-low byte mask afterwards |
| ad_i | input | 32 | Shared lines as seen by the target (address, then write data) |
| ad_o | output | 32 | Read data the target places on the shared lines |
| ad_oe | output | 1 | Enable for the target to drive the shared lines |
| devsel_n | output | 1 | Target claims the transaction, active low |
| trdy_n | output | 1 | Target ready for the data phase, active low |
| mem_ready | input | 1 | Local memory can be accessed this cycle |

## Verification
A bad decode or a wrong latched word index shows on the ports within one cycle: `devsel_n` is missing, or present for a miss, in the turnaround cycle, or `ad_o` is wrong in the first ready cycle. A miscounted wait state moves the fall of `trdy_n` by a cycle. A controller that fails to return to idle leaves `devsel_n` low in the cycle after completion, and the next transaction's idle check catches it. A wrong byte-lane write cannot be seen at once. It only appears when the same word is read back later, so the random traffic revisits a small set of word indices many times.

// File: rtl/mxbus_pkg.sv
`timescale 1ns/1ps
package mxbus_pkg;
  localparam int BUS_W     = 32;
  localparam int BUS_LANES = BUS_W / 8;

  localparam logic [3:0] CMD_WORD_READ  = 4'b0110;
  localparam logic [3:0] CMD_WORD_WRITE = 4'b0111;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_SKIP   = 2'd2
  } tgt_state_e;
endpackage

// File: rtl/mxbus_window_decode.sv
`timescale 1ns/1ps
module mxbus_window_decode import mxbus_pkg::*; #(
  parameter logic [31:0] BASE_ADDR = 32'h0004_0000,
  parameter int          IDX_W     = 8
) (
  input  logic [BUS_W-1:0] addr,
  input  logic [3:0]       cmd,
  output logic             claim,
  output logic             claim_wr,
  output logic [IDX_W-1:0] idx
);
  localparam int WIN_LOG2 = IDX_W + 2;

  logic       base_match;
  logic       cmd_rd;
  logic       cmd_wr;
  logic [1:0] unused_low;

  assign base_match = (addr[BUS_W-1:WIN_LOG2] == BASE_ADDR[BUS_W-1:WIN_LOG2]);
  assign cmd_rd     = (cmd == CMD_WORD_READ);
  assign cmd_wr     = (cmd == CMD_WORD_WRITE);
  assign claim      = base_match && (cmd_rd || cmd_wr);
  assign claim_wr   = cmd_wr;
  assign idx        = addr[WIN_LOG2-1:2];
  assign unused_low = addr[1:0];
endmodule

// File: rtl/mxbus_lane_ram.sv
`timescale 1ns/1ps
module mxbus_lane_ram #(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rdata <= mem[idx];
  end
endmodule

// File: rtl/mxbus_target_ctrl.sv
`timescale 1ns/1ps
module mxbus_target_ctrl import mxbus_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             mem_ready,
  input  logic             claim,
  input  logic             claim_wr,
  input  logic [IDX_W-1:0] idx_in,
  output logic [IDX_W-1:0] idx_q,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             ad_oe,
  output logic             rd_en,
  output logic             wr_en
);
  tgt_state_e state;
  logic       wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      ad_oe    <= 1'b0;
      wr_q     <= 1'b0;
      idx_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!frame_n) begin
            idx_q <= idx_in;
            wr_q  <= claim_wr;
            if (claim) begin
              state    <= ST_ACCESS;
              devsel_n <= 1'b0;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_SKIP: begin
          if (frame_n) state <= ST_IDLE;
        end
        ST_ACCESS: begin
          if (trdy_n) begin
            if (mem_ready) begin
              trdy_n <= 1'b0;
              ad_oe  <= !wr_q;
            end
          end else if (!irdy_n) begin
            trdy_n   <= 1'b1;
            devsel_n <= 1'b1;
            ad_oe    <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Memory is read in the cycle ready is first seen, so data and trdy_n appear together.
  assign rd_en = (state == ST_ACCESS) && trdy_n && mem_ready && !wr_q;
  // Writes commit only on the completing edge.
  assign wr_en = (state == ST_ACCESS) && !trdy_n && !irdy_n && wr_q;
endmodule

// File: rtl/mxbus_target.sv
`timescale 1ns/1ps
module mxbus_target import mxbus_pkg::*; #(
  parameter int          WORDS     = 256,
  parameter logic [31:0] BASE_ADDR = 32'h0004_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  input  logic [BUS_LANES-1:0] cbe_n,
  input  logic [BUS_W-1:0]     ad_i,
  output logic [BUS_W-1:0]     ad_o,
  output logic                 ad_oe,
  output logic                 devsel_n,
  output logic                 trdy_n,
  input  logic                 mem_ready
);
  localparam int IDX_W = $clog2(WORDS);

  logic             claim;
  logic             claim_wr;
  logic [IDX_W-1:0] idx_dec;
  logic [IDX_W-1:0] idx_q;
  logic             rd_en;
  logic             wr_en;

  mxbus_window_decode #(.BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_decode (
    .addr     (ad_i),
    .cmd      (cbe_n),
    .claim    (claim),
    .claim_wr (claim_wr),
    .idx      (idx_dec)
  );

  mxbus_target_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .mem_ready (mem_ready),
    .claim     (claim),
    .claim_wr  (claim_wr),
    .idx_in    (idx_dec),
    .idx_q     (idx_q),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .ad_oe     (ad_oe),
    .rd_en     (rd_en),
    .wr_en     (wr_en)
  );

  for (genvar g = 0; g < BUS_LANES; g++) begin : g_lane
    mxbus_lane_ram #(.DEPTH(WORDS), .IDX_W(IDX_W)) u_ram (
      .clk   (clk),
      .rd_en (rd_en),
      .wr_en (wr_en && !cbe_n[g]),
      .idx   (idx_q),
      .wdata (ad_i[8*g +: 8]),
      .rdata (ad_o[8*g +: 8])
    );
  end
endmodule

// File: rtl/mxbus_target_chk.sv
`timescale 1ns/1ps
module mxbus_target_chk (
  input logic        clk,
  input logic        rst,
  input logic        irdy_n,
  input logic        mem_ready,
  input logic [31:0] ad_o,
  input logic        ad_oe,
  input logic        devsel_n,
  input logic        trdy_n
);
  // R3: no drive in the turnaround cycle where the claim first shows
  a_r3_turnaround_float: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> (!ad_oe && trdy_n));

  // R4: a wait state persists while memory is not ready
  a_r4_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n && trdy_n && !mem_ready) |=> trdy_n);

  // R4: ready memory produces trdy_n in the next cycle
  a_r4_ready_follows: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n && trdy_n && mem_ready) |=> !trdy_n);

  // R2: trdy_n and drive only under a claim
  a_r2_ready_needs_claim: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n || ad_oe) |-> !devsel_n);

  // R5: drive only alongside target ready
  a_r5_drive_with_ready: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !trdy_n);

  // R6: release after completion
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && !irdy_n) |=> (trdy_n && devsel_n && !ad_oe));

  // R7: hold data while the initiator stalls
  a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_o)));
endmodule

bind mxbus_target mxbus_target_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .irdy_n    (irdy_n),
  .mem_ready (mem_ready),
  .ad_o      (ad_o),
  .ad_oe     (ad_oe),
  .devsel_n  (devsel_n),
  .trdy_n    (trdy_n)
);

// File: tb/test_mxbus_target.sv
`timescale 1ns/1ps
module test_mxbus_target;
  localparam int          WORDS     = 256;
  localparam logic [31:0] BASE      = 32'h0004_0000;
  localparam int          WIN_BYTES = WORDS * 4;
  localparam logic [3:0]  C_RD      = 4'b0110;
  localparam logic [3:0]  C_WR      = 4'b0111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n, irdy_n, mem_ready;
  logic [3:0]  cbe_n;
  logic [31:0] ad_i, ad_o;
  logic        ad_oe, devsel_n, trdy_n;

  logic [31:0] exp_mem [WORDS];
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mxbus_target #(.WORDS(WORDS), .BASE_ADDR(BASE)) i_mxbus_target (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .mem_ready(mem_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                        input logic [3:0] be_n);
    logic [31:0] r = old_w;
    for (int k = 0; k < 4; k++) if (!be_n[k]) r[8*k +: 8] = new_w[8*k +: 8];
    return r;
  endfunction

  function automatic bit in_window(input logic [31:0] a);
    return (a >= BASE) && (a < BASE + WIN_BYTES);
  endfunction

  task automatic txn(input logic [31:0] addr, input logic [3:0] cmd, input logic [3:0] be_n,
                     input logic [31:0] wdata, input int dly, input int idly);
    bit hit = in_window(addr) && (cmd == C_RD || cmd == C_WR);
    bit wr  = (cmd == C_WR);
    int idx = int'(addr[9:2]);
    logic [31:0] exp_rd = exp_mem[idx];
    bit done = 0;
    bit exp_t;
    @(negedge clk);
    chk(devsel_n && trdy_n && !ad_oe, "R3 idle before address cycle", {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
    frame_n = 1'b0; cbe_n = cmd; ad_i = addr; irdy_n = 1'b1; mem_ready = 1'($urandom);
    @(negedge clk);
    chk(devsel_n == !hit, "R2 claim in turnaround", {31'd0, devsel_n}, {31'd0, !hit});
    chk(!ad_oe, "R3 no drive in turnaround", {31'd0, ad_oe}, 32'd0);
    chk(trdy_n, "R4 no ready in turnaround", {31'd0, trdy_n}, 32'd1);
    frame_n = 1'b1; cbe_n = be_n; ad_i = wr ? wdata : $urandom;
    irdy_n = !(idly == 0); mem_ready = (dly == 0);
    if (!hit) begin
      for (int c = 2; c < 7; c++) begin
        @(negedge clk);
        chk(devsel_n && trdy_n && !ad_oe, "R9 miss ignored", {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
        mem_ready = 1'($urandom);
      end
      irdy_n = 1'b1;
    end else begin
      for (int c = 2; c < 64 && !done; c++) begin
        @(negedge clk);
        exp_t = (c >= dly + 2);
        chk(!devsel_n, "R2 claim held", {31'd0, devsel_n}, 32'd0);
        chk(trdy_n == !exp_t, "R4 wait states", {31'd0, trdy_n}, {31'd0, !exp_t});
        if (exp_t && !wr) begin
          chk(ad_oe, "R5 drive on read", {31'd0, ad_oe}, 32'd1);
          if (c > dly + 2) chk(ad_o == exp_rd, "R7 read data held", ad_o, exp_rd);
          else             chk(ad_o == exp_rd, "R5 read data", ad_o, exp_rd);
        end
        if (wr) chk(!ad_oe, "R3 no drive on write", {31'd0, ad_oe}, 32'd0);
        mem_ready = (c - 1 >= dly);
        irdy_n    = !(c - 1 >= idly);
        if (exp_t && (c - 1 >= idly)) begin
          done = 1;
          if (wr) exp_mem[idx] = merge(exp_mem[idx], wdata, be_n);
        end
      end
      @(negedge clk);
      chk(devsel_n && trdy_n && !ad_oe, "R6 release after completion", {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
      irdy_n = 1'b1; mem_ready = 1'($urandom); ad_i = $urandom; cbe_n = 4'($urandom);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    logic [31:0] a;
    logic [3:0]  k;
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'h0; ad_i = 32'h0; mem_ready = 1'b0;
    a = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    chk(devsel_n && trdy_n && !ad_oe, "R1 reset state", {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
    rst = 1'b0;

    // Fill every word with a full-mask write (R8)
    for (int i = 0; i < WORDS; i++) begin
      exp_mem[i] = 32'h0;
      txn(BASE + 32'(i * 4), C_WR, 4'h0, 32'hC3000000 ^ (32'(i) * 32'h00010203), 0, 0);
    end
    // Directed corners
    txn(BASE, C_RD, 4'h0, 0, 0, 0);                       // R5 zero-wait read
    txn(BASE + 32'h10, C_WR, 4'b1010, 32'h11223344, 3, 1); // R8 partial bytes
    txn(BASE + 32'h10, C_RD, 4'h0, 0, 5, 8);               // R4/R7 long waits
    txn(BASE + WIN_BYTES - 4, C_RD, 4'h0, 0, 1, 0);        // R2 top word
    txn(BASE + WIN_BYTES, C_WR, 4'h0, 32'hDEADBEEF, 0, 0); // R9 just above
    txn(BASE - 4, C_WR, 4'h0, 32'hDEADBEEF, 0, 0);         // R9 just below
    txn(BASE + 32'h10, 4'b0011, 4'h0, 32'hDEADBEEF, 0, 0); // R9 other command
    txn(BASE + 32'h10, C_RD, 4'h0, 0, 0, 2);               // R9 word unchanged
    txn(BASE + 32'h20, C_WR, 4'hF, 32'hFFFFFFFF, 2, 0);    // R8 empty mask
    txn(BASE + 32'h20, C_RD, 4'h0, 0, 0, 0);
    // Random traffic over a small set of words
    for (int n = 0; n < 400; n++) begin
      a = BASE + {22'd0, 4'($urandom), 2'($urandom), 2'b00};
      case ($urandom % 10)
        0: txn(BASE + WIN_BYTES + 32'(($urandom % 64) * 4), C_RD, 4'h0, 0, 0, 0);
        1: txn(BASE - 32'((1 + $urandom % 16) * 4), C_WR, 4'h0, $urandom, 0, 0);
        2: begin
             k = 4'($urandom);
             if (k == C_RD || k == C_WR) k = 4'b1100;
             txn(a, k, 4'h0, $urandom, 0, 0);
           end
        default: txn(a, ($urandom % 2) ? C_WR : C_RD, 4'($urandom), $urandom,
                     int'($urandom % 5), int'($urandom % 4));
      endcase
    end
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
    $finish;
  end
endmodule